// File: doc/BRIEF.md
# Key-Sequenced Configuration Write Guard

This block sits in front of the configuration registers of a timekeeping core and decides which register writes reach them. Software sees a small write bus. One address is a key register: the guard opens only after two specific byte values are written to it, one after the other. While it is closed, every write aimed at the protected registers is dropped. Any later write to the key register closes it again at once.

The guard also runs the handshake that freezes the calendar. Software sets a request bit in a control register. After a fixed number of clock edges the guard raises an acknowledge, which means the calendar counters are stopped and time and date may be loaded. Clearing the request drops the acknowledge and lets the calendar run. Writing to the control register is itself a protected write.

The guard holds no protected register contents. It forwards the address and data of the write, together with a gated strobe, to the register file behind it.

Top module: `cfg_write_guard`

## Requirements
- R1: After a synchronous reset the guard is locked, `unlocked`=0, `init_req`=0, `init_ack`=0 and `cal_run`=1.
- R2: The key register is at address 0. Writing 0xCA and then 0x53 to it on two consecutive key-register writes sets `unlocked` to 1 from the clock edge of the second write onward. Writes to other addresses between the two key writes do not break the sequence.
- R3: A first key write other than 0xCA leaves the guard locked. A second key write other than 0x53 (0xCA included) returns the guard to waiting for 0xCA, so a following 0x53 alone does not unlock.
- R4: While unlocked, any write to the key register relocks the guard at that edge. A value of 0xCA in that write also counts as the first key of a new sequence.
- R5: A write to any address of 2 or higher raises `prot_wr_en` in the same cycle (combinationally) only while `unlocked`=1. `prot_wr_addr` and `prot_wr_data` mirror the bus. Addresses 0 and 1 never raise `prot_wr_en`.
- R6: The control register is at address 1, with bit 0 as the init request. A control write updates `init_req` at its clock edge only while unlocked. While locked it is ignored.
- R7: `init_ack` rises INIT_DELAY clock edges (default 2) after the edge that set `init_req`. `cal_run` is always the inverse of `init_ack`.
- R8: Clearing `init_req` drops `init_ack` one edge later. Writing the request bit as 1 again while `init_ack` is already 1 keeps `init_ack` high with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe of the register bus |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prot_wr_en | output | 1 | Gated write strobe to the protected registers |
| prot_wr_addr | output | ADDR_W | Forwarded write address |
| prot_wr_data | output | DATA_W | Forwarded write data |
| unlocked | output | 1 | Protected writes currently allowed |
| init_req | output | 1 | Init-mode request bit |
| init_ack | output | 1 | Calendar frozen, time and date may be loaded |
| cal_run | output | 1 | Calendar counting enable |

## Verification
The bench sweeps all 256 values as the first key and all 256 values as the second key. A decoder that matched only some key bits, or that treated a repeated 0xCA as a valid restart, would unlock on the wrong byte or stay locked after a correct pair. It also checks that writes to other addresses between the keys do not break the sequence, that 0xCA written while open both relocks and arms the next sequence, and that a second 0xCA leaves the guard waiting for a fresh first key. It sweeps the strobe gating over every address in both lock states, since a decoder that let addresses 0 or 1 through would corrupt the register file. On the init side it samples the exact edge at which the acknowledge rises and falls, and it checks that a repeated request does not glitch the acknowledge low and that a control write while locked leaves the request untouched.

// File: rtl/cfgwp_pkg.sv
package cfgwp_pkg;

    typedef enum logic [1:0] {
        KS_WAIT_FIRST  = 2'd0,
        KS_WAIT_SECOND = 2'd1,
        KS_OPEN        = 2'd2
    } key_state_t;

    typedef struct packed {
        logic key_wr;
        logic ctrl_wr;
        logic prot_wr;
    } bus_decode_t;

    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;
    localparam int         CTRL_INIT_BIT = 0;

    function automatic key_state_t key_next(input key_state_t cur, input logic [7:0] v);
        key_state_t nxt;
        case (cur)
            KS_WAIT_FIRST:  nxt = (v == KEY_FIRST)  ? KS_WAIT_SECOND : KS_WAIT_FIRST;
            KS_WAIT_SECOND: nxt = (v == KEY_SECOND) ? KS_OPEN        : KS_WAIT_FIRST;
            KS_OPEN:        nxt = (v == KEY_FIRST)  ? KS_WAIT_SECOND : KS_WAIT_FIRST;
            default:        nxt = KS_WAIT_FIRST;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cfgwp_decode.sv
module cfgwp_decode
    import cfgwp_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int KEY_ADDR  = 0,
    parameter int CTRL_ADDR = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              unlocked,
    output bus_decode_t       dec
);
    localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic hit_key;
    logic hit_ctrl;

    always_comb begin
        hit_key      = (wr_addr == KEY_A);
        hit_ctrl     = (wr_addr == CTRL_A);
        dec.key_wr   = wr_en && hit_key;
        dec.ctrl_wr  = wr_en && hit_ctrl && unlocked;
        dec.prot_wr  = wr_en && !hit_key && !hit_ctrl && unlocked;
    end

    // R5: the gated strobe never fires for the guard's own two addresses
    always_comb begin
        assert_own_addr_R5: assert (!(dec.prot_wr && (hit_key || hit_ctrl)))
            else $error("protected strobe on guard address");
    end
endmodule

// File: rtl/cfgwp_key_fsm.sv
module cfgwp_key_fsm
    import cfgwp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              unlocked
);
    key_state_t state_q;
    key_state_t state_d;
    logic [7:0] key_byte;

    always_comb begin
        key_byte = key_data[7:0];
        state_d  = state_q;
        if (key_wr) state_d = key_next(state_q, key_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_WAIT_FIRST;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == KS_OPEN);

    // R2: opening is always caused by a second key following an accepted first key
    assert_open_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(key_wr) && $past(key_byte) == KEY_SECOND
                             && $past(state_q) == KS_WAIT_SECOND));

    // R4: a key write while open always closes
    assert_relock_R4: assert property (@(posedge clk) disable iff (rst)
        (unlocked && key_wr) |=> !unlocked);

    // R3: a wrong second key returns to waiting for the first
    assert_bad_second_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_WAIT_SECOND && key_wr && key_byte != KEY_SECOND)
            |=> (state_q == KS_WAIT_FIRST));
endmodule

// File: rtl/cfgwp_init_hs.sv
module cfgwp_init_hs
    import cfgwp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int INIT_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_data,
    output logic              init_req,
    output logic              init_ack
);
    localparam int CNT_W = (INIT_DELAY < 2) ? 1 : $clog2(INIT_DELAY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_DELAY - 1);

    logic [CNT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst)          init_req <= 1'b0;
        else if (ctrl_wr) init_req <= ctrl_data[CTRL_INIT_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst || !init_req) begin
            wait_cnt <= '0;
            init_ack <= 1'b0;
        end else if (!init_ack) begin
            if (wait_cnt == CNT_LAST) init_ack <= 1'b1;
            else                      wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // R7: the acknowledge never rises without a standing request
    assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(init_ack) |-> ($past(init_req) && init_req));

    // R8: a withdrawn request takes the acknowledge down one edge later
    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !init_req |=> !init_ack);

    // R8: a repeated request while acknowledged keeps the acknowledge high
    assert_ack_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (init_ack && init_req && !(ctrl_wr && !ctrl_data[CTRL_INIT_BIT])) |=> init_ack);
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
    import cfgwp_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int KEY_ADDR   = 0,
    parameter int CTRL_ADDR  = 1,
    parameter int INIT_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot_wr_en,
    output logic [ADDR_W-1:0] prot_wr_addr,
    output logic [DATA_W-1:0] prot_wr_data,
    output logic              unlocked,
    output logic              init_req,
    output logic              init_ack,
    output logic              cal_run
);
    bus_decode_t dec;

    cfgwp_decode #(
        .ADDR_W   (ADDR_W),
        .KEY_ADDR (KEY_ADDR),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .unlocked(unlocked),
        .dec     (dec)
    );

    cfgwp_key_fsm #(
        .DATA_W(DATA_W)
    ) u_key (
        .clk     (clk),
        .rst     (rst),
        .key_wr  (dec.key_wr),
        .key_data(wr_data),
        .unlocked(unlocked)
    );

    cfgwp_init_hs #(
        .DATA_W    (DATA_W),
        .INIT_DELAY(INIT_DELAY)
    ) u_init (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (dec.ctrl_wr),
        .ctrl_data(wr_data),
        .init_req (init_req),
        .init_ack (init_ack)
    );

    assign prot_wr_en   = dec.prot_wr;
    assign prot_wr_addr = wr_addr;
    assign prot_wr_data = wr_data;
    assign cal_run      = !init_ack;

    // R5: nothing reaches the protected registers while locked
    assert_locked_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !prot_wr_en);

    // R6: a control write while locked leaves the request bit alone
    assert_ctrl_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> $stable(init_req));

    // R1: reset leaves the guard closed and the calendar running
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!unlocked && !init_req && !init_ack && cal_run));
endmodule

// File: tb/cfg_write_guard_tb_top.sv
module cfg_write_guard_tb_top;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              prot_wr_en;
    logic [ADDR_W-1:0] prot_wr_addr;
    logic [DATA_W-1:0] prot_wr_data;
    logic              unlocked;
    logic              init_req;
    logic              init_ack;
    logic              cal_run;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_write_guard dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prot_wr_en(prot_wr_en), .prot_wr_addr(prot_wr_addr), .prot_wr_data(prot_wr_data),
        .unlocked(unlocked), .init_req(init_req), .init_ack(init_ack), .cal_run(cal_run)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic bus_wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic relock();
        bus_wr(0, 8'hFF);
    endtask

    task automatic open_guard();
        relock();
        bus_wr(0, 8'hCA);
        bus_wr(0, 8'h53);
    endtask

    task automatic probe_strobe(input int a, input int d, input int exp_en);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        #2;
        check("R5 strobe", int'(prot_wr_en), exp_en);
        check("R5 addr pass", int'(prot_wr_addr), a);
        check("R5 data pass", int'(prot_wr_data), d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 unlocked", int'(unlocked), 0);
        check("R1 init_req", int'(init_req), 0);
        check("R1 init_ack", int'(init_ack), 0);
        check("R1 cal_run", int'(cal_run), 1);

        // R2/R3 sweep of the first key
        for (int v = 0; v < 256; v++) begin
            relock();
            bus_wr(0, v);
            bus_wr(0, 8'h53);
            check((v == 8'hCA) ? "R2 first key sweep" : "R3 first key sweep",
                  int'(unlocked), (v == 8'hCA) ? 1 : 0);
        end

        // R2/R3 sweep of the second key
        for (int v = 0; v < 256; v++) begin
            relock();
            bus_wr(0, 8'hCA);
            bus_wr(0, v);
            check((v == 8'h53) ? "R2 second key sweep" : "R3 second key sweep",
                  int'(unlocked), (v == 8'h53) ? 1 : 0);
        end

        // R3: repeated 0xCA then 0x53 alone must not open
        relock();
        bus_wr(0, 8'hCA);
        bus_wr(0, 8'hCA);
        bus_wr(0, 8'h53);
        check("R3 double first key", int'(unlocked), 0);

        // R2: unrelated writes between the keys keep the sequence
        relock();
        bus_wr(0, 8'hCA);
        bus_wr(7, 8'h11);
        bus_wr(1, 8'h00);
        bus_wr(0, 8'h53);
        check("R2 interleaved writes", int'(unlocked), 1);

        // R4: any key write while open relocks; 0xCA arms the next sequence
        bus_wr(0, 8'h00);
        check("R4 relock value 00", int'(unlocked), 0);
        open_guard();
        bus_wr(0, 8'hCA);
        check("R4 relock value CA", int'(unlocked), 0);
        bus_wr(0, 8'h53);
        check("R4 CA arms next sequence", int'(unlocked), 1);

        // R5: strobe gating over every address, locked then unlocked
        relock();
        for (int a = 0; a < 16; a++) begin
            if (a != 0) probe_strobe(a, 8'h5A ^ a, 0);
        end
        check("R5 still locked", int'(unlocked), 0);
        open_guard();
        for (int a = 15; a >= 1; a--) begin
            probe_strobe(a, 8'hA5 ^ a, (a >= 2) ? 1 : 0);
        end
        check("R6 ctrl write of 0 kept request low", int'(init_req), 0);
        probe_strobe(0, 8'hFF, 0);
        check("R5 key write relocked", int'(unlocked), 0);

        // R6: control write while locked is ignored
        bus_wr(1, 8'h01);
        check("R6 locked ctrl ignored req", int'(init_req), 0);
        @(negedge clk);
        @(negedge clk);
        check("R6 locked ctrl ignored ack", int'(init_ack), 0);

        // R7: acknowledge timing
        open_guard();
        bus_wr(1, 8'h01);
        check("R6 ctrl accepted", int'(init_req), 1);
        check("R7 ack edge 0", int'(init_ack), 0);
        @(negedge clk);
        check("R7 ack edge 1", int'(init_ack), 0);
        check("R7 cal_run edge 1", int'(cal_run), 1);
        @(negedge clk);
        check("R7 ack edge 2", int'(init_ack), 1);
        check("R7 cal_run frozen", int'(cal_run), 0);

        // R8: repeated request keeps acknowledge high
        bus_wr(1, 8'h01);
        check("R8 repeat keeps ack", int'(init_ack), 1);
        @(negedge clk);
        check("R8 repeat keeps ack later", int'(init_ack), 1);

        // R6: locked clear attempt ignored
        relock();
        bus_wr(1, 8'h00);
        check("R6 locked clear ignored", int'(init_req), 1);
        check("R6 locked clear ack", int'(init_ack), 1);

        // R8: clearing drops acknowledge one edge later
        open_guard();
        bus_wr(1, 8'h00);
        check("R8 req cleared", int'(init_req), 0);
        check("R8 ack before drop", int'(init_ack), 1);
        @(negedge clk);
        check("R8 ack dropped", int'(init_ack), 0);
        check("R8 cal_run resumes", int'(cal_run), 1);

        // R7: request again, counter restarts from zero
        bus_wr(1, 8'h01);
        @(negedge clk);
        check("R7 restart edge 1", int'(init_ack), 0);
        @(negedge clk);
        check("R7 restart edge 2", int'(init_ack), 1);

        // R1: reset mid-operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset unlocked", int'(unlocked), 0);
        check("R1 reset init_req", int'(init_req), 0);
        check("R1 reset init_ack", int'(init_ack), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule